// File: doc/BRIEF.md
# LCD Panel Bring-up and Window Write Sequencer

This block drives a small colour LCD controller over an 8080-style parallel write bus. The bus has an active-low write strobe, a data/command select line and a 16-bit data path. After synchronous reset it runs a fixed power-up script without help from anything else. The script sets the pixel bus format, takes the panel out of sleep, opens a window over the full visible area, starts a memory write and paints every pixel white. It then waits a fixed time, switches the display on and waits again. Once that script is complete the block goes idle.

From idle, a host can do three things. It can request a rectangular window given in visible-area coordinates. The block then programs the column and row ranges, starts a memory write and forwards exactly enough pixel words from a valid/ready stream to fill the rectangle. The host can also ask for the display to be switched off (suspend) or on again (resume). Each of these sends one command and does not repeat the power-up script. A `busy` output tells the host when it may make a request.

Panel geometry, the visible-area column offset, the bus mode (16-bit RGB565 or 8-bit RGB666), the strobe width, the system clock rate and the two pauses are all parameters. In 8-bit mode the 16-bit bus is kept, and only its low byte carries meaning for the panel.

Top module: `lcd_bringup_seq`

## Requirements
- R1: After reset the write order is: 0xBC (format), its one parameter, 0x94 (sleep exit), 0x15 (column set) with parameters first-column, 0, last-column, 0, then 0x75 (row set) with parameters first-row, 0, last-row, 0, then 0x5C (memory write), then the fill, then 0xAF (display on).
- R2: `lcd_dc` is 0 for every opcode write and 1 for every parameter, fill and pixel write. Parameter bytes appear on `lcd_d[7:0]` with `lcd_d[15:8]` zero.
- R3: The format parameter is 0x28 when BUS16=1 (16-bit RGB565) and 0x08 when BUS16=0 (8-bit RGB666).
- R4: The power-up window covers panel columns COL_OFS to COL_OFS+H_RES-1 and rows 0 to V_RES-1.
- R5: The fill writes 0xFFFF with `lcd_dc`=1, H_RES*V_RES times when BUS16=1 and 3*H_RES*V_RES times when BUS16=0.
- R6: The gap from the last fill write to display-on is at least PAUSE_PRE_MS*CLK_HZ/1000 cycles and at most 4 cycles more. The gap from display-on to `busy` falling is at least PAUSE_POST_MS*CLK_HZ/1000 cycles and at most 4 cycles more.
- R7: `busy` is high from the end of reset until the power-up script, including the final pause, has finished, and high whenever a write is in progress. While `busy` is low the strobe stays high.
- R8: Each write holds `lcd_wr_n` low for exactly STROBE_CYC cycles, with `lcd_d` and `lcd_dc` stable throughout. The panel takes the value on the rising edge.
- R9: A window request with inputs c0<=c1 and r0<=r1 produces 0x15 with parameters c0+COL_OFS, 0, c1+COL_OFS, 0, then 0x75 with parameters r0, 0, r1, 0, then 0x5C. After that exactly (c1-c0+1)*(r1-r0+1) stream words are written in order with `lcd_dc`=1, and the block returns to idle. `pix_ready` is high only while `busy` is high and the strobe is high.
- R10: Window, suspend and resume requests that arrive while `busy` is high produce no writes.
- R11: A suspend request writes only 0xAE and a resume request writes only 0xAF, each with `lcd_dc`=0.
- R12: When several requests are high in the same idle cycle, window wins over suspend and suspend wins over resume. Only the winner produces writes.
- R13: During reset `lcd_wr_n` is high and `pix_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts the power-up script when released |
| win_req | input | 1 | Request a window write (sampled while idle) |
| win_col_first | input | XW | First visible column of the window |
| win_col_last | input | XW | Last visible column of the window |
| win_row_first | input | YW | First row of the window |
| win_row_last | input | YW | Last row of the window |
| susp_req | input | 1 | Request display off |
| resume_req | input | 1 | Request display on |
| pix_valid | input | 1 | Pixel word available on the stream |
| pix_data | input | 16 | Pixel word |
| pix_ready | output | 1 | The block takes the pixel word on this cycle |
| busy | output | 1 | Sequence or write in progress; requests are ignored |
| lcd_wr_n | output | 1 | Active-low write strobe |
| lcd_dc | output | 1 | 0 = opcode, 1 = parameter or pixel data |
| lcd_d | output | 16 | Panel data bus |

## Verification
The assertions assume that window coordinates satisfy first<=last within the visible area. They also assume that `pix_valid` and `pix_data` stay stable until the word is taken. The bench meets both conditions: it draws each last-coordinate at random from the range between the first-coordinate and the edge, and it changes stream data only in the cycle after a handshake. Requests sent while `busy` is high are deliberately injected, and the bench then checks that no extra writes reach the bus.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;

    localparam int BUS_W = 16;

    // panel opcodes
    localparam logic [7:0] OP_FORMAT = 8'hBC;
    localparam logic [7:0] OP_WAKE   = 8'h94;
    localparam logic [7:0] OP_COLS   = 8'h15;
    localparam logic [7:0] OP_ROWS   = 8'h75;
    localparam logic [7:0] OP_MEMWR  = 8'h5C;
    localparam logic [7:0] OP_ON     = 8'hAF;
    localparam logic [7:0] OP_OFF    = 8'hAE;

    // format parameter per bus mode
    localparam logic [7:0] FMT_565 = 8'h28;
    localparam logic [7:0] FMT_666 = 8'h08;

    localparam logic [BUS_W-1:0] WHITE = 16'hFFFF;

    // script step indices: power-up starts at 0, window requests at WIN_FIRST
    localparam logic [3:0] WIN_FIRST   = 4'd3;
    localparam logic [3:0] SCRIPT_LAST = 4'd13;

    typedef struct packed {
        logic             dc;
        logic [BUS_W-1:0] data;
    } bus_word_t;

    typedef struct packed {
        logic [7:0] col_lo;
        logic [7:0] col_hi;
        logic [7:0] row_lo;
        logic [7:0] row_hi;
    } window_t;

    typedef enum logic [2:0] {
        ST_SCRIPT,
        ST_FILL,
        ST_PAUSE_PRE,
        ST_DISP_ON,
        ST_PAUSE_POST,
        ST_IDLE,
        ST_STREAM,
        ST_SINGLE
    } seq_state_t;

    function automatic bus_word_t cmd_word(input logic [7:0] op);
        bus_word_t w;
        w.dc   = 1'b0;
        w.data = {8'h00, op};
        return w;
    endfunction

    function automatic bus_word_t arg_word(input logic [7:0] v);
        bus_word_t w;
        w.dc   = 1'b1;
        w.data = {8'h00, v};
        return w;
    endfunction

    // One entry of the command script; the window fields supply the ranges.
    function automatic bus_word_t script_word(input logic [3:0] idx,
                                              input logic [7:0] fmt,
                                              input window_t    win);
        bus_word_t w;
        case (idx)
            4'd0:    w = cmd_word(OP_FORMAT);
            4'd1:    w = arg_word(fmt);
            4'd2:    w = cmd_word(OP_WAKE);
            4'd3:    w = cmd_word(OP_COLS);
            4'd4:    w = arg_word(win.col_lo);
            4'd6:    w = arg_word(win.col_hi);
            4'd8:    w = cmd_word(OP_ROWS);
            4'd9:    w = arg_word(win.row_lo);
            4'd11:   w = arg_word(win.row_hi);
            4'd13:   w = cmd_word(OP_MEMWR);
            default: w = arg_word(8'h00);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lcdq_strobe.sv
module lcdq_strobe
    import lcdq_pkg::*;
#(
    parameter int STROBE_CYC = 4
)(
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  bus_word_t word_in,
    output logic      idle,
    output logic      wr_n,
    output bus_word_t word_out
);

    localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

    typedef enum logic [1:0] {P_IDLE, P_LOW, P_REC} phase_t;

    phase_t         phase;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= P_IDLE;
            wr_n     <= 1'b1;
            cnt      <= '0;
            word_out <= '0;
        end else begin
            case (phase)
                P_IDLE: begin
                    if (go) begin
                        word_out <= word_in;
                        wr_n     <= 1'b0;
                        cnt      <= CW'(STROBE_CYC - 1);
                        phase    <= P_LOW;
                    end
                end
                P_LOW: begin
                    if (cnt == '0) begin
                        wr_n  <= 1'b1;
                        phase <= P_REC;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= P_IDLE;
            endcase
        end
    end

    assign idle = (phase == P_IDLE);

endmodule

// File: rtl/lcdq_ms_timer.sv
module lcdq_ms_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int MSW    = 8
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [MSW-1:0] ms_target,
    output logic           done
);

    localparam int TPM = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int PW  = (TPM > 1) ? $clog2(TPM) : 1;

    logic [PW-1:0]  pre;
    logic [MSW-1:0] ms;
    logic           pre_wrap;

    assign pre_wrap = (pre == PW'(TPM - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre <= '0;
            ms  <= '0;
        end else if (pre_wrap) begin
            pre <= '0;
            ms  <= ms + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign done = run && pre_wrap && (ms == ms_target - 1'b1);

endmodule

// File: rtl/lcdq_seq.sv
module lcdq_seq
    import lcdq_pkg::*;
#(
    parameter int H_RES         = 176,
    parameter int V_RES         = 220,
    parameter int COL_OFS       = 2,
    parameter int BUS16         = 1,
    parameter int PAUSE_PRE_MS  = 80,
    parameter int PAUSE_POST_MS = 200,
    parameter int XW            = 8,
    parameter int YW            = 8,
    parameter int CNT_W         = 17,
    parameter int MSW           = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             win_req,
    input  logic [XW-1:0]    win_c0,
    input  logic [XW-1:0]    win_c1,
    input  logic [YW-1:0]    win_r0,
    input  logic [YW-1:0]    win_r1,
    input  logic             susp_req,
    input  logic             resume_req,
    input  logic             pix_valid,
    input  logic [BUS_W-1:0] pix_data,
    input  logic             strobe_idle,
    input  logic             timer_done,
    output logic             go,
    output bus_word_t        word,
    output logic             timer_run,
    output logic [MSW-1:0]   ms_target,
    output logic             pix_ready,
    output logic             busy
);

    localparam int         FILL_N  = H_RES * V_RES * ((BUS16 != 0) ? 1 : 3);
    localparam logic [7:0] FMT_SEL = (BUS16 != 0) ? FMT_565 : FMT_666;

    localparam window_t FULL_WIN = '{
        col_lo: 8'(COL_OFS),
        col_hi: 8'(COL_OFS + H_RES - 1),
        row_lo: 8'd0,
        row_hi: 8'(V_RES - 1)
    };

    seq_state_t       state;
    logic [3:0]       idx;
    logic             boot;
    window_t          win;
    logic [CNT_W-1:0] remain;
    logic [7:0]       single_op;
    logic             accept;
    logic [CNT_W-1:0] span_w, span_h;

    assign accept = (state == ST_IDLE) && strobe_idle;
    assign busy   = !accept;
    assign span_w = CNT_W'(win_c1) - CNT_W'(win_c0) + 1'b1;
    assign span_h = CNT_W'(win_r1) - CNT_W'(win_r0) + 1'b1;

    // word selection and launch
    always_comb begin
        go        = 1'b0;
        word      = '0;
        pix_ready = 1'b0;
        timer_run = 1'b0;
        ms_target = MSW'(PAUSE_PRE_MS);
        case (state)
            ST_SCRIPT: begin
                go   = strobe_idle;
                word = script_word(idx, FMT_SEL, win);
            end
            ST_FILL: begin
                go   = strobe_idle;
                word = '{dc: 1'b1, data: WHITE};
            end
            ST_PAUSE_PRE: begin
                timer_run = strobe_idle;
            end
            ST_DISP_ON: begin
                go   = strobe_idle;
                word = cmd_word(OP_ON);
            end
            ST_PAUSE_POST: begin
                timer_run = strobe_idle;
                ms_target = MSW'(PAUSE_POST_MS);
            end
            ST_STREAM: begin
                pix_ready = strobe_idle;
                go        = strobe_idle && pix_valid;
                word      = '{dc: 1'b1, data: pix_data};
            end
            ST_SINGLE: begin
                go   = strobe_idle;
                word = cmd_word(single_op);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SCRIPT;
            idx       <= '0;
            boot      <= 1'b1;
            win       <= FULL_WIN;
            remain    <= CNT_W'(FILL_N);
            single_op <= OP_OFF;
        end else begin
            case (state)
                ST_SCRIPT: begin
                    if (go) begin
                        if (idx == SCRIPT_LAST) begin
                            state <= boot ? ST_FILL : ST_STREAM;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_FILL: begin
                    if (go) begin
                        if (remain == CNT_W'(1)) state <= ST_PAUSE_PRE;
                        else                     remain <= remain - 1'b1;
                    end
                end
                ST_PAUSE_PRE: begin
                    if (timer_done) state <= ST_DISP_ON;
                end
                ST_DISP_ON: begin
                    if (go) state <= ST_PAUSE_POST;
                end
                ST_PAUSE_POST: begin
                    if (timer_done) begin
                        state <= ST_IDLE;
                        boot  <= 1'b0;
                    end
                end
                ST_STREAM: begin
                    if (go) begin
                        if (remain == CNT_W'(1)) state <= ST_IDLE;
                        else                     remain <= remain - 1'b1;
                    end
                end
                ST_SINGLE: begin
                    if (go) state <= ST_IDLE;
                end
                default: begin
                    if (accept) begin
                        if (win_req) begin
                            win.col_lo <= 8'(win_c0) + 8'(COL_OFS);
                            win.col_hi <= 8'(win_c1) + 8'(COL_OFS);
                            win.row_lo <= 8'(win_r0);
                            win.row_hi <= 8'(win_r1);
                            remain     <= span_w * span_h;
                            idx        <= WIN_FIRST;
                            state      <= ST_SCRIPT;
                        end else if (susp_req) begin
                            single_op <= OP_OFF;
                            state     <= ST_SINGLE;
                        end else if (resume_req) begin
                            single_op <= OP_ON;
                            state     <= ST_SINGLE;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq
    import lcdq_pkg::*;
#(
    parameter int H_RES         = 176,
    parameter int V_RES         = 220,
    parameter int COL_OFS       = 2,
    parameter int BUS16         = 1,
    parameter int CLK_HZ        = 50_000_000,
    parameter int STROBE_CYC    = 4,
    parameter int PAUSE_PRE_MS  = 80,
    parameter int PAUSE_POST_MS = 200,
    localparam int XW = (H_RES > 1) ? $clog2(H_RES) : 1,
    localparam int YW = (V_RES > 1) ? $clog2(V_RES) : 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          win_req,
    input  logic [XW-1:0] win_col_first,
    input  logic [XW-1:0] win_col_last,
    input  logic [YW-1:0] win_row_first,
    input  logic [YW-1:0] win_row_last,
    input  logic          susp_req,
    input  logic          resume_req,
    input  logic          pix_valid,
    input  logic [15:0]   pix_data,
    output logic          pix_ready,
    output logic          busy,
    output logic          lcd_wr_n,
    output logic          lcd_dc,
    output logic [15:0]   lcd_d
);

    localparam int CNT_W  = $clog2(H_RES * V_RES * 3 + 1);
    localparam int MS_MAX = (PAUSE_PRE_MS > PAUSE_POST_MS) ? PAUSE_PRE_MS : PAUSE_POST_MS;
    localparam int MSW    = $clog2(MS_MAX + 1);

    logic           go, strobe_idle, timer_run, timer_done;
    bus_word_t      word, bus_word;
    logic [MSW-1:0] ms_target;

    lcdq_seq #(
        .H_RES(H_RES), .V_RES(V_RES), .COL_OFS(COL_OFS), .BUS16(BUS16),
        .PAUSE_PRE_MS(PAUSE_PRE_MS), .PAUSE_POST_MS(PAUSE_POST_MS),
        .XW(XW), .YW(YW), .CNT_W(CNT_W), .MSW(MSW)
    ) u_seq (
        .clk(clk), .rst(rst),
        .win_req(win_req), .win_c0(win_col_first), .win_c1(win_col_last),
        .win_r0(win_row_first), .win_r1(win_row_last),
        .susp_req(susp_req), .resume_req(resume_req),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .strobe_idle(strobe_idle), .timer_done(timer_done),
        .go(go), .word(word), .timer_run(timer_run), .ms_target(ms_target),
        .pix_ready(pix_ready), .busy(busy)
    );

    lcdq_strobe #(.STROBE_CYC(STROBE_CYC)) u_strobe (
        .clk(clk), .rst(rst), .go(go), .word_in(word),
        .idle(strobe_idle), .wr_n(lcd_wr_n), .word_out(bus_word)
    );

    lcdq_ms_timer #(.CLK_HZ(CLK_HZ), .MSW(MSW)) u_timer (
        .clk(clk), .rst(rst), .run(timer_run),
        .ms_target(ms_target), .done(timer_done)
    );

    assign lcd_dc = bus_word.dc;
    assign lcd_d  = bus_word.data;

endmodule

// File: rtl/lcdq_checker.sv
module lcdq_checker #(
    parameter int STROBE_CYC = 4
)(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        pix_ready,
    input logic        lcd_wr_n,
    input logic        lcd_dc,
    input logic [15:0] lcd_d
);

    localparam int LW = $clog2(STROBE_CYC + 2);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || lcd_wr_n)                   low_cnt <= '0;
        else if (low_cnt != LW'(STROBE_CYC + 1)) low_cnt <= low_cnt + 1'b1;
    end

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> lcd_wr_n);                                        // R7

    AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> busy);                                        // R9

    AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> lcd_wr_n);                                    // R9

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!lcd_wr_n && !$fell(lcd_wr_n)) |-> ($stable(lcd_d) && $stable(lcd_dc))); // R8

    AST_STROBE_MAX: assert property (@(posedge clk) disable iff (rst)
        !lcd_wr_n |-> (low_cnt < LW'(STROBE_CYC)));                 // R8

    AST_STROBE_EXACT: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_wr_n) |-> (low_cnt == LW'(STROBE_CYC)));          // R8

endmodule

bind lcd_bringup_seq lcdq_checker #(.STROBE_CYC(STROBE_CYC)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .pix_ready(pix_ready),
    .lcd_wr_n(lcd_wr_n), .lcd_dc(lcd_dc), .lcd_d(lcd_d)
);

// File: tb/test_lcd_bringup_seq.sv
`timescale 1ns/1ps
module test_lcd_bringup_seq;

    localparam int H    = 8;
    localparam int V    = 6;
    localparam int OFS  = 2;
    localparam int CHZ  = 20000;
    localparam int TPM  = CHZ / 1000;
    localparam int SC_A = 2;
    localparam int SC_B = 1;
    localparam int PRE  = 80;
    localparam int POST = 200;
    localparam int LOGN = 2048;

    logic clk = 0;
    logic rst = 1;
    always #2 clk = ~clk;

    logic        win_req = 0, susp_req = 0, resume_req = 0, pix_valid = 0;
    logic [2:0]  c0 = 0, c1 = 0;
    logic [2:0]  r0 = 0, r1 = 0;
    logic [15:0] pix_data = 0;
    logic        pix_ready, busy, lcd_wr_n, lcd_dc;
    logic [15:0] lcd_d;
    logic        pix_ready_b, busy_b, wr_n_b, dc_b;
    logic [15:0] d_b;

    lcd_bringup_seq #(.H_RES(H), .V_RES(V), .COL_OFS(OFS), .BUS16(1), .CLK_HZ(CHZ),
        .STROBE_CYC(SC_A), .PAUSE_PRE_MS(PRE), .PAUSE_POST_MS(POST)) i_lcd_bringup_seq (
        .clk(clk), .rst(rst), .win_req(win_req), .win_col_first(c0), .win_col_last(c1),
        .win_row_first(r0), .win_row_last(r1), .susp_req(susp_req), .resume_req(resume_req),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready), .busy(busy),
        .lcd_wr_n(lcd_wr_n), .lcd_dc(lcd_dc), .lcd_d(lcd_d));

    lcd_bringup_seq #(.H_RES(H), .V_RES(V), .COL_OFS(OFS), .BUS16(0), .CLK_HZ(CHZ),
        .STROBE_CYC(SC_B), .PAUSE_PRE_MS(PRE), .PAUSE_POST_MS(POST)) i_lcd_bringup_seq_b8 (
        .clk(clk), .rst(rst), .win_req(1'b0), .win_col_first(3'd0), .win_col_last(3'd0),
        .win_row_first(3'd0), .win_row_last(3'd0), .susp_req(1'b0), .resume_req(1'b0),
        .pix_valid(1'b0), .pix_data(16'h0), .pix_ready(pix_ready_b), .busy(busy_b),
        .lcd_wr_n(wr_n_b), .lcd_dc(dc_b), .lcd_d(d_b));

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    // bus monitor: log every write on the strobe's rising edge
    logic [16:0] log_a [LOGN];
    int          rise_t [LOGN];
    int          fall_t [LOGN];
    int          n_a = 0, bad_w = 0, fall_a = 0, boot_idle_t = -1;
    logic        prev_a = 1, prev_busy = 1;
    int          n_b = 0, ff_b = 0, bad_wb = 0, fall_b = 0;
    logic [16:0] fmt_b = 0, last_b = 0;
    logic        prev_b = 1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            prev_a = 1; prev_b = 1; prev_busy = 1;
        end else begin
            if (prev_a && !lcd_wr_n) fall_a = cyc;
            if (!prev_a && lcd_wr_n) begin
                log_a[n_a]  = {lcd_dc, lcd_d};
                rise_t[n_a] = cyc;
                fall_t[n_a] = fall_a;
                if (cyc - fall_a != SC_A) bad_w++;
                if (n_a < LOGN - 1) n_a++;
            end
            prev_a = lcd_wr_n;
            if (prev_busy && !busy && boot_idle_t < 0) boot_idle_t = cyc;
            prev_busy = busy;
            if (prev_b && !wr_n_b) fall_b = cyc;
            if (!prev_b && wr_n_b) begin
                if (n_b == 1) fmt_b = {dc_b, d_b};
                if ({dc_b, d_b} == 17'h1FFFF) ff_b++;
                if (cyc - fall_b != SC_B) bad_wb++;
                last_b = {dc_b, d_b};
                n_b++;
            end
            prev_b = wr_n_b;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] boot_word(input int i, input logic [7:0] fmt);
        case (i)
            0:  return {1'b0, 16'h00BC};
            1:  return {1'b1, 8'h00, fmt};
            2:  return {1'b0, 16'h0094};
            3:  return {1'b0, 16'h0015};
            4:  return {1'b1, 16'(OFS)};
            6:  return {1'b1, 16'(OFS + H - 1)};
            8:  return {1'b0, 16'h0075};
            11: return {1'b1, 16'(V - 1)};
            13: return {1'b0, 16'h005C};
            default: return {1'b1, 16'h0000};
        endcase
    endfunction

    function automatic logic [16:0] win_word(input int i, input int a0, input int a1,
                                             input int b0, input int b1);
        case (i)
            0:  return {1'b0, 16'h0015};
            1:  return {1'b1, 16'(a0 + OFS)};
            3:  return {1'b1, 16'(a1 + OFS)};
            5:  return {1'b0, 16'h0075};
            6:  return {1'b1, 16'(b0)};
            8:  return {1'b1, 16'(b1)};
            10: return {1'b0, 16'h005C};
            default: return {1'b1, 16'h0000};
        endcase
    endfunction

    logic [15:0] px_exp [64];

    task automatic send_px(input int n);
        for (int i = 0; i < n; i++) begin
            int gap;
            gap = $urandom % 3;
            repeat (gap) @(negedge clk);
            pix_data  = 16'($urandom);
            px_exp[i] = pix_data;
            pix_valid = 1;
            while (!pix_ready) @(negedge clk);
            @(negedge clk);
            pix_valid = 0;
        end
    endtask

    task automatic run_win(input int a0, input int a1, input int b0, input int b1,
                           input bit all_req);
        int base, npx;
        base = n_a;
        c0 = 3'(a0); c1 = 3'(a1); r0 = 3'(b0); r1 = 3'(b1);
        win_req = 1;
        if (all_req) begin susp_req = 1; resume_req = 1; end
        @(negedge clk);
        win_req = 0; susp_req = 0; resume_req = 0;
        chk(busy == 1'b1, "R9 busy after window request", busy, 1);
        // poke while busy: must be ignored
        susp_req = 1; resume_req = 1; win_req = 1;
        @(negedge clk);
        susp_req = 0; resume_req = 0; win_req = 0;
        npx = (a1 - a0 + 1) * (b1 - b0 + 1);
        send_px(npx);
        do @(negedge clk); while (busy);
        chk(n_a - base == 11 + npx, "R10 R12 write count for window", n_a - base, 11 + npx);
        for (int i = 0; i < 11; i++)
            chk(log_a[base + i] == win_word(i, a0, a1, b0, b1), "R9 window command",
                log_a[base + i], win_word(i, a0, a1, b0, b1));
        for (int i = 0; i < npx; i++)
            chk(log_a[base + 11 + i] == {1'b1, px_exp[i]}, "R9 R2 pixel word",
                log_a[base + 11 + i], {1'b1, px_exp[i]});
        chk(pix_ready == 1'b0, "R9 ready low after window", pix_ready, 0);
    endtask

    task automatic single(input bit off);
        int base;
        logic [16:0] e;
        base = n_a;
        e = off ? {1'b0, 16'h00AE} : {1'b0, 16'h00AF};
        if (off) susp_req = 1; else resume_req = 1;
        @(negedge clk);
        susp_req = 0; resume_req = 0;
        chk(busy == 1'b1, "R11 busy during single command", busy, 1);
        do @(negedge clk); while (busy);
        chk(n_a - base == 1, "R11 single write count", n_a - base, 1);
        chk(log_a[base] == e, "R11 single opcode", log_a[base], e);
    endtask

    bit finished = 0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int a0, a1, b0, b1;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        chk(lcd_wr_n == 1'b1, "R13 strobe high in reset", lcd_wr_n, 1);
        chk(pix_ready == 1'b0, "R13 ready low in reset", pix_ready, 0);
        rst = 0;
        @(negedge clk);
        chk(busy == 1'b1, "R7 busy after reset", busy, 1);
        // requests during power-up must be ignored
        repeat (20) @(negedge clk);
        win_req = 1; susp_req = 1; resume_req = 1;
        @(negedge clk);
        win_req = 0; susp_req = 0; resume_req = 0;
        while (n_a < 63) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R7 busy during final pause", busy, 1);
        do @(negedge clk); while (busy || busy_b);
        @(negedge clk);

        chk(n_a == 63, "R10 R5 power-up write count", n_a, 63);
        for (int i = 0; i < 14; i++)
            chk(log_a[i] == boot_word(i, 8'h28), "R1 R2 R3 R4 power-up word",
                log_a[i], boot_word(i, 8'h28));
        begin
            int ff;
            ff = 0;
            for (int i = 14; i < 62; i++) if (log_a[i] == 17'h1FFFF) ff++;
            chk(ff == H * V, "R5 16-bit fill words", ff, H * V);
        end
        chk(log_a[62] == {1'b0, 16'h00AF}, "R1 display on last", log_a[62], 17'h000AF);
        chk((fall_t[62] - rise_t[61] >= PRE * TPM) && (fall_t[62] - rise_t[61] <= PRE * TPM + 4),
            "R6 pre pause", fall_t[62] - rise_t[61], PRE * TPM);
        chk((boot_idle_t - rise_t[62] >= POST * TPM) && (boot_idle_t - rise_t[62] <= POST * TPM + 4),
            "R6 post pause", boot_idle_t - rise_t[62], POST * TPM);
        chk(bad_w == 0, "R8 strobe width 16-bit", bad_w, 0);
        chk(bad_wb == 0, "R8 strobe width 8-bit", bad_wb, 0);
        chk(fmt_b == {1'b1, 16'h0008}, "R3 8-bit format parameter", fmt_b, 17'h10008);
        chk(ff_b == 3 * H * V, "R5 8-bit fill words", ff_b, 3 * H * V);
        chk(n_b == 14 + 3 * H * V + 1, "R5 8-bit write count", n_b, 14 + 3 * H * V + 1);
        chk(last_b == {1'b0, 16'h00AF}, "R1 8-bit display on", last_b, 17'h000AF);

        single(1'b1);   // R11 suspend
        single(1'b0);   // R11 resume
        chk(n_a == 65, "R11 no script repeat", n_a, 65);

        run_win(0, H - 1, 0, V - 1, 1'b1);   // R12 priority, full window
        run_win(H - 1, H - 1, V - 1, V - 1, 1'b0);
        run_win(0, 0, 0, 0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            a0 = $urandom % H; a1 = a0 + ($urandom % (H - a0));
            b0 = $urandom % V; b1 = b0 + ($urandom % (V - b0));
            run_win(a0, a1, b0, b1, 1'b0);
        end
        chk(bad_w == 0, "R8 strobe width after windows", bad_w, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule